// File: doc/BRIEF.md
# Multi-Node Coherency Response Combiner

This block sequences one coherency request from the requesting node of a fully connected system with up to four nodes. When the local cache misses, the block accepts the request and sends an address broadcast. It then collects one partial response from each remote node that is configured in the node mask. Once every configured node has answered, it reduces the answers to one combined response, which goes back to all remote nodes. It then waits for a final response from each configured node. Each final response means that node has finished its coherency work and released its resources. After the last final response arrives, the block reports completion to the local cache.

The reduction follows a fixed priority order, and the numerically smallest code wins. Two nodes that both claim intervention-master ownership cannot both be right. The block flags this as an error and turns the result into a reject. A rejected combined response does not complete the request: after the final responses, the block starts over with a new broadcast. A system-wide fairness input holds off new local requests while any rejected request is outstanding anywhere. Retries of a request already in flight go ahead regardless.

Top module: `coh_req_seq`

## Requirements
- R1: While idle, the block accepts a request (`reqAccept` high in that cycle) when `reqValid` is high and `fairBlock` is low. `bcastValid` is high for exactly the next cycle.
- R2: A partial response is ignored in four cases: its node is not set in the mask captured at acceptance, its node has already answered in this round, it arrives while the block is not collecting, or its valid bit is low.
- R3: `combValid` pulses for one cycle, two cycles after the cycle in which the last required partial response is presented. With an empty mask, it pulses two cycles after `bcastValid`. The three pulses `bcastValid`, `combValid` and `doneValid` are never high together.
- R4: Partial code encoding: 0 = owner hit with invalidations sent, 1 = owner hit, 2 = owner reject, 3 = memory-home reject, 4 = shared hit with invalidations sent, 5 = shared hit, 6 = local-owner hit, 7 = miss. Node i uses `prespCode[3i+2:3i]`. The combined code is the smallest valid code collected, or 7 if no node answered.
- R5: If two or more nodes report code 0 or 1 in the same round, `errFlag` is high together with `combValid`, and the combined code is forced to 2.
- R6: For a combined code other than 2 or 3, `doneValid` pulses two cycles after the cycle in which the last required final response is presented. `doneCode` equals the combined code in that cycle.
- R7: For a combined code of 2 or 3, the block still collects all final responses. It then issues a new `bcastValid` instead of `doneValid`, two cycles after the last final response.
- R8: `earlyOk` is high together with `combValid` exactly when the combined code is 1, 5, 6 or 7.
- R9: `fairBlock` prevents acceptance in the idle state only. It does not delay a retry broadcast.
- R10: During and straight after reset, `reqAccept`, `bcastValid`, `combValid`, `errFlag`, `earlyOk` and `doneValid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Local miss request pending |
| fairBlock | input | 1 | Some rejected request is outstanding in the system |
| nodeMask | input | NODES | Configured remote nodes, captured at acceptance |
| reqAccept | output | 1 | Request taken this cycle |
| bcastValid | output | 1 | Address broadcast pulse |
| prespValid | input | NODES | Partial response valid, one bit per node |
| prespCode | input | 3*NODES | Partial response codes, 3 bits per node |
| combValid | output | 1 | Combined response pulse to all remote nodes |
| combCode | output | 3 | Combined response code |
| errFlag | output | 1 | Inconsistent partial responses seen |
| earlyOk | output | 1 | Early completion to the processor is allowed |
| frespValid | input | NODES | Final response valid, one bit per node |
| doneValid | output | 1 | Request complete pulse |
| doneCode | output | 3 | Combined code of the completed request |

## Verification
The assertions check the per-cycle relations on every cycle:
- a broadcast always follows an acceptance, and `fairBlock` always stops acceptance;
- an error forces the reject code, and `earlyOk` appears only with an allowed code;
- the three phase pulses never overlap, and a reject is never followed by completion.

Only the bench scenarios can show the ordering and reduction behaviour:
- the reduction picks the right minimum across different node masks;
- responses from unconfigured nodes and duplicate responses leave the result unchanged;
- the empty-mask case completes;
- a reject or error triggers a second round that ends with a fresh code.

// File: rtl/coh_seq_pkg.sv
package coh_seq_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    RSP_IM_XI    = 3'd0,
    RSP_IM       = 3'd1,
    RSP_IM_REJ   = 3'd2,
    RSP_MM_REJ   = 3'd3,
    RSP_RO_XI    = 3'd4,
    RSP_RO       = 3'd5,
    RSP_LOCAL_IM = 3'd6,
    RSP_MISS     = 3'd7
  } rspCode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BCAST, ST_PART, ST_COMB, ST_FINAL, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic latchMask;
    logic clrPart;
    logic capPart;
    logic clrFinal;
    logic capFinal;
  } seqStrobe_t;
endpackage

// File: rtl/coh_seq_dp.sv
module coh_seq_dp
  import coh_seq_pkg::*;
#(
  parameter int NODES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic [NODES-1:0]          nodeMask,
  input  logic [NODES-1:0]          prespValid,
  input  logic [NODES*CODE_W-1:0]   prespCode,
  input  logic [NODES-1:0]          frespValid,
  output logic                      allPart,
  output logic                      allFinal,
  output logic [CODE_W-1:0]         combCode,
  output logic                      combErr
);
  localparam logic [CODE_W-1:0] OWNER_MAX = RSP_IM;
  localparam logic [CODE_W-1:0] NONE_CODE = RSP_MISS;

  logic [NODES-1:0]  maskQ, gotPart, gotFinal, newPart;
  logic [CODE_W-1:0] nodeCode [NODES];
  logic [CODE_W-1:0] bestQ, bestD;
  logic              ownQ, ownD, errQ, errD;

  for (genvar g = 0; g < NODES; g++) begin : g_slice
    assign nodeCode[g] = prespCode[g*CODE_W +: CODE_W];
  end

  assign newPart = prespValid & maskQ & ~gotPart;

  always_comb begin
    bestD = bestQ;
    ownD  = ownQ;
    errD  = errQ;
    for (int i = 0; i < NODES; i++) begin
      if (newPart[i]) begin
        if (nodeCode[i] < bestD) bestD = nodeCode[i];
        if (nodeCode[i] <= OWNER_MAX) begin
          if (ownD) errD = 1'b1;
          ownD = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ    <= '0;
      gotPart  <= '0;
      gotFinal <= '0;
      bestQ    <= NONE_CODE;
      ownQ     <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (strb.latchMask) maskQ <= nodeMask;
      if (strb.clrPart) begin
        gotPart <= '0;
        bestQ   <= NONE_CODE;
        ownQ    <= 1'b0;
        errQ    <= 1'b0;
      end else if (strb.capPart) begin
        gotPart <= gotPart | newPart;
        bestQ   <= bestD;
        ownQ    <= ownD;
        errQ    <= errD;
      end
      if (strb.clrFinal)      gotFinal <= '0;
      else if (strb.capFinal) gotFinal <= gotFinal | (frespValid & maskQ);
    end
  end

  assign allPart  = (gotPart == maskQ);
  assign allFinal = (gotFinal == maskQ);
  assign combErr  = errQ;
  assign combCode = errQ ? RSP_IM_REJ : bestQ;
endmodule

// File: rtl/coh_seq_ctl.sv
module coh_seq_ctl
  import coh_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              fairBlock,
  input  logic              allPart,
  input  logic              allFinal,
  input  logic [CODE_W-1:0] combCode,
  input  logic              combErr,
  output seqStrobe_t        strb,
  output logic              reqAccept,
  output logic              bcastValid,
  output logic              combValid,
  output logic              errFlag,
  output logic              earlyOk,
  output logic              doneValid
);
  seqState_t stateQ, stateD;
  logic      isReject, xiPending;

  assign isReject  = (combCode == RSP_IM_REJ) || (combCode == RSP_MM_REJ);
  assign xiPending = (combCode == RSP_IM_XI) || (combCode == RSP_RO_XI);
  assign reqAccept = (stateQ == ST_IDLE) && reqValid && !fairBlock;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: if (reqAccept) begin
        strb.latchMask = 1'b1;
        stateD = ST_BCAST;
      end
      ST_BCAST: begin
        strb.clrPart = 1'b1;
        stateD = ST_PART;
      end
      ST_PART: begin
        strb.capPart = 1'b1;
        if (allPart) stateD = ST_COMB;
      end
      ST_COMB: begin
        strb.clrFinal = 1'b1;
        stateD = ST_FINAL;
      end
      ST_FINAL: begin
        strb.capFinal = 1'b1;
        if (allFinal) stateD = isReject ? ST_BCAST : ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign bcastValid = (stateQ == ST_BCAST);
  assign combValid  = (stateQ == ST_COMB);
  assign doneValid  = (stateQ == ST_DONE);
  assign errFlag    = combValid && combErr;
  assign earlyOk    = combValid && !isReject && !xiPending;
endmodule

// File: rtl/coh_req_seq.sv
module coh_req_seq
  import coh_seq_pkg::*;
#(
  parameter int NODES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    fairBlock,
  input  logic [NODES-1:0]        nodeMask,
  output logic                    reqAccept,
  output logic                    bcastValid,
  input  logic [NODES-1:0]        prespValid,
  input  logic [NODES*CODE_W-1:0] prespCode,
  output logic                    combValid,
  output logic [CODE_W-1:0]       combCode,
  output logic                    errFlag,
  output logic                    earlyOk,
  input  logic [NODES-1:0]        frespValid,
  output logic                    doneValid,
  output logic [CODE_W-1:0]       doneCode
);
  seqStrobe_t        strb;
  logic              allPart, allFinal, combErr;
  logic [CODE_W-1:0] dpCode;

  coh_seq_dp #(.NODES(NODES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .nodeMask(nodeMask),
    .prespValid(prespValid), .prespCode(prespCode), .frespValid(frespValid),
    .allPart(allPart), .allFinal(allFinal), .combCode(dpCode), .combErr(combErr)
  );

  coh_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .fairBlock(fairBlock),
    .allPart(allPart), .allFinal(allFinal), .combCode(dpCode), .combErr(combErr),
    .strb(strb), .reqAccept(reqAccept), .bcastValid(bcastValid),
    .combValid(combValid), .errFlag(errFlag), .earlyOk(earlyOk),
    .doneValid(doneValid)
  );

  assign combCode = dpCode;
  assign doneCode = dpCode;
endmodule

// File: rtl/coh_seq_chk.sv
module coh_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       fairBlock,
  input logic       reqAccept,
  input logic       bcastValid,
  input logic       combValid,
  input logic [2:0] combCode,
  input logic       errFlag,
  input logic       earlyOk,
  input logic       doneValid
);
  // R1
  accept_bcast_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAccept |=> bcastValid);

  // R9
  fair_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fairBlock |-> !reqAccept);

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bcastValid, combValid, doneValid}));

  // R3
  comb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    combValid |=> !combValid);

  // R5
  err_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (combValid && combCode == 3'd2));

  // R8
  early_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    earlyOk |-> (combValid && (combCode == 3'd1 || combCode >= 3'd5)));

  // R7
  reject_no_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (combValid && (combCode == 3'd2 || combCode == 3'd3)) |=> !doneValid);
endmodule

bind coh_req_seq coh_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .fairBlock(fairBlock), .reqAccept(reqAccept),
  .bcastValid(bcastValid), .combValid(combValid), .combCode(combCode),
  .errFlag(errFlag), .earlyOk(earlyOk), .doneValid(doneValid)
);

// File: tb/sim_coh_req_seq.sv
module sim_coh_req_seq;
  localparam int NODES = 4;
  localparam int CW    = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, reqValid, fairBlock;
  logic [NODES-1:0] nodeMask, prespValid, frespValid;
  logic [NODES*CW-1:0] prespCode;
  logic reqAccept, bcastValid, combValid, errFlag, earlyOk, doneValid;
  logic [CW-1:0] combCode, doneCode;

  coh_req_seq #(.NODES(NODES)) u0 (.*);

  int checks = 0, fails = 0, wd = 0;
  int bcastCnt = 0, combCnt = 0, doneCnt = 0, lastDone = -1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: phase 0 idle,1 broadcast,2 collect,3 combined,4 finals,5 done
  int mPhase = 0, mBest = 7, mOwn = 0;
  logic [NODES-1:0] mMask = '0, mGot = '0;

  function automatic int expCode();
    return (mOwn > 1) ? 2 : mBest;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mBest = 7; mOwn = 0; mMask = '0; mGot = '0;
    end else begin
      case (mPhase)
        0: if (reqValid && !fairBlock) begin mMask = nodeMask; mPhase = 1; end
        1: begin mGot = '0; mBest = 7; mOwn = 0; mPhase = 2; end
        2: begin
          if (mGot == mMask) mPhase = 3;
          for (int i = 0; i < NODES; i++)
            if (prespValid[i] && mMask[i] && !mGot[i]) begin
              int c;
              c = int'(prespCode[i*CW +: CW]);
              mGot[i] = 1'b1;
              if (c < mBest) mBest = c;
              if (c <= 1) mOwn++;
            end
        end
        3: begin mGot = '0; mPhase = 4; end
        4: begin
          if (mGot == mMask) mPhase = (expCode() == 2 || expCode() == 3) ? 1 : 5;
          mGot = mGot | (frespValid & mMask);
        end
        default: mPhase = 0;
      endcase
    end
  end

  int ec;
  bit rej, exAcc;
  always @(negedge clk) begin
    if (rstN) begin
      ec = expCode();
      rej = (ec == 2 || ec == 3);
      exAcc = (mPhase == 0) && reqValid && !fairBlock;
      chk(reqAccept == exAcc, "R9 reqAccept", reqAccept, exAcc);
      chk(bcastValid == (mPhase == 1), "R1 bcastValid", bcastValid, mPhase == 1);
      chk(combValid == (mPhase == 3), "R3 combValid", combValid, mPhase == 3);
      if (mPhase == 3) begin
        chk(combCode == ec, "R4 combCode", combCode, ec);
        chk(errFlag == (mOwn > 1), "R5 errFlag", errFlag, mOwn > 1);
        chk(earlyOk == (!rej && ec != 0 && ec != 4), "R8 earlyOk", earlyOk,
            !rej && ec != 0 && ec != 4);
      end else begin
        chk(!errFlag && !earlyOk, "R5 quiet flags", {errFlag, earlyOk}, 0);
      end
      chk(doneValid == (mPhase == 5), "R6 doneValid", doneValid, mPhase == 5);
      if (mPhase == 5) chk(doneCode == ec, "R6 doneCode", doneCode, ec);
      if (bcastValid) bcastCnt++;
      if (combValid)  combCnt++;
      if (doneValid) begin doneCnt++; lastDone = int'(doneCode); end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [NODES*CW-1:0] pk(int n0, int n1, int n2, int n3);
    return {3'(n3), 3'(n2), 3'(n1), 3'(n0)};
  endfunction

  // runs one request; every node answers each round, then repeats with all-zero codes
  task automatic doReq(input logic [NODES-1:0] mask, input logic [NODES*CW-1:0] c1,
                       input logic [NODES*CW-1:0] c2, input bit blockAfter,
                       input int wantRounds, input int wantCode, input string tag);
    int b0, c0, d0, rounds;
    b0 = bcastCnt; c0 = combCnt; d0 = doneCnt; rounds = 0;
    @(posedge clk); #1;
    nodeMask = mask; reqValid = 1'b1;
    while (doneCnt == d0) begin
      while (bcastCnt == b0 + rounds) @(posedge clk);
      #1;
      reqValid = 1'b0;
      if (blockAfter) fairBlock = 1'b1;
      rounds++;
      prespValid = '1;
      prespCode  = (rounds == 1) ? c1 : c2;
      @(posedge clk); #1;
      prespCode = '0;               // duplicates carrying the strongest code (R2)
      @(posedge clk); #1;
      prespValid = '0;
      while (combCnt < c0 + rounds) @(posedge clk);
      #1;
      frespValid = '1;
      @(posedge clk); #1;
      frespValid = '0;
      while (doneCnt == d0 && bcastCnt == b0 + rounds) @(posedge clk);
    end
    fairBlock = 1'b0;
    chk(rounds == wantRounds, {tag, " rounds"}, rounds, wantRounds);
    chk(lastDone == wantCode, {tag, " final code"}, lastDone, wantCode);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; fairBlock = 1'b0; nodeMask = '0;
    prespValid = '0; prespCode = '0; frespValid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 outputs quiet in reset
    chk({reqAccept, bcastValid, combValid, errFlag, earlyOk, doneValid} == 6'b0,
        "R10 reset outputs", {reqAccept, bcastValid, combValid, errFlag, earlyOk, doneValid}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    chk({bcastValid, combValid, doneValid} == 3'b0, "R10 after reset",
        {bcastValid, combValid, doneValid}, 0);

    // R4 single node shared hit
    doReq(4'b0001, pk(5, 7, 7, 7), pk(7, 7, 7, 7), 1'b0, 1, 5, "R4 single");
    // R2 unconfigured node 2 reports 0 and is ignored; R8 no early for code 4
    doReq(4'b1011, pk(7, 4, 0, 6), pk(7, 7, 7, 7), 1'b0, 1, 4, "R2 mask1011");
    // R5 two owners -> error -> retry; R9 fairBlock does not stop the retry
    doReq(4'b1111, pk(1, 7, 0, 7), pk(7, 7, 7, 7), 1'b1, 2, 7, "R5 R9 conflict");
    // R7 memory-home reject then shared hit
    doReq(4'b0110, pk(7, 3, 5, 7), pk(7, 5, 6, 7), 1'b0, 2, 5, "R7 mmreject");
    // R3 empty mask completes with miss
    doReq(4'b0000, pk(0, 0, 0, 0), pk(0, 0, 0, 0), 1'b0, 1, 7, "R3 empty");
    // R7 owner reject then single owner hit (R8 early allowed)
    doReq(4'b1100, pk(7, 7, 6, 2), pk(7, 7, 1, 6), 1'b0, 2, 1, "R7 imreject");

    // R9 fairness holds off a new request
    @(posedge clk); #1;
    fairBlock = 1'b1; reqValid = 1'b1; nodeMask = 4'b0001;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!reqAccept, "R9 blocked accept", reqAccept, 0);
    end
    @(posedge clk); #1;
    reqValid = 1'b0; fairBlock = 1'b0;
    @(negedge clk);
    chk(bcastValid == 1'b0, "R9 no broadcast while blocked", bcastValid, 0);

    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule